// File: doc/BRIEF.md
# Two-Phase Early-Termination SAD Engine

This block scores candidate motion vectors for a single 16x16 current block. For each candidate it measures the sum of absolute differences (SAD) in two halves. The first half covers the even rows, at one row of 16 pixels per cycle. When that partial score already reaches the best score found so far, the candidate is dropped and the second half never runs. Otherwise the odd rows are scored from a copy kept inside the block, so the caller does not send them again, and the two halves are added to give the full score.

The block keeps the lowest full SAD and the vector that produced it. Each search opens with the predicted vector as its first candidate. That candidate is always scored in full, and its score becomes the initial bound for the candidates after it. The caller first loads the current block row by row. It then streams each candidate as eight beats, and each beat carries one even row and the odd row below it. A one-cycle completion pulse then presents the winning vector, its SAD, and the number of candidates that stopped after the first half.

The odd-row half of one candidate runs at the same time as the even-row half of the next. The decision for each candidate is therefore exactly what a strictly sequential search would give.

Top module: `two_phase_sad_engine`

## Requirements
- R1: After reset, cur_ready is 1 and cand_ready, done, best_sad, best_mv_x, best_mv_y and skip_count are all 0.
- R2: The current block is taken as 16 accepted cur_row beats, rows 0 to 15 in order, with pixel p of a row in bits [8p+7:8p]. After the 16th accepted beat, cur_ready is 0 and cand_ready is 1.
- R3: A candidate is 8 accepted beats. Beat k carries row 2k in cand_pair[127:0] and row 2k+1 in cand_pair[255:128], with the same pixel layout as R2. cand_mv_x, cand_mv_y (two's complement) and cand_last are taken on the eighth beat.
- R4: The partial SAD of the even rows is compared with the best full SAD so far, including a full result that completes in the same cycle. If the partial SAD is not strictly smaller, the candidate is dropped and skip_count rises by one.
- R5: A candidate that is not dropped has its odd rows scored over the next 8 cycles from the stored copy. Its full SAD is the partial SAD plus the odd-row SAD.
- R6: The best SAD and vector change only on a strictly smaller full SAD. On a tie the earlier candidate is kept.
- R7: The bound is all ones at the start of each search, so the first candidate (the predicted vector) is always scored in full and seeds the bound.
- R8: The full SAD is 16 bits wide and is exact up to the largest possible value, 65280.
- R9: done is a one-cycle pulse. It is high in the cycle after the clock edge that accepts the last candidate's eighth beat when that candidate is dropped, and 8 cycles later when it is scored in full. best_sad, best_mv_x, best_mv_y and skip_count hold the search result from then until the next search.
- R10: cand_ready stays 1 from the end of loading until the last candidate's eighth beat, and the next candidate may follow while odd rows are still being scored. cand_ready is 0 from that beat until done, after which cur_ready is 1 again and cur_ready and cand_ready are never both 1.
- R11: Cycles with cand_valid low between beats do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_valid | input | 1 | Current-block row valid |
| cur_ready | output | 1 | Engine accepts current-block rows |
| cur_row | input | 128 | One current-block row, 16 pixels |
| cand_valid | input | 1 | Candidate beat valid |
| cand_ready | output | 1 | Engine accepts candidate beats |
| cand_pair | input | 256 | Even row (low half) and the odd row below it (high half) |
| cand_mv_x | input | 8 | Horizontal vector tag, signed |
| cand_mv_y | input | 8 | Vertical vector tag, signed |
| cand_last | input | 1 | Marks the last candidate of the search |
| done | output | 1 | One-cycle search-complete pulse |
| best_mv_x | output | 8 | Horizontal component of the winning vector |
| best_mv_y | output | 8 | Vertical component of the winning vector |
| best_sad | output | 16 | SAD of the winning vector |
| skip_count | output | 16 | Candidates dropped after the even rows |

## Verification
A bound that is wrong or stale inside the engine changes which candidates are dropped. It shows first in skip_count at the completion pulse, and in best_sad or the winning vector whenever the dropped candidate would have won. A slip in the odd-row sequencing shows as a full SAD that is off by one row's worth of differences. It also shows as a completion pulse that comes in the wrong cycle, which the bench checks on every clock. Ties, a candidate that passes the first half but loses overall, a dropped final candidate, idle cycles between beats and the largest possible SAD each force these symptoms into the open within one search.

// File: rtl/tps_pkg.sv
package tps_pkg;
    localparam int PIX_W      = 8;
    localparam int BLK        = 16;
    localparam int ROWS       = 16;
    localparam int HALF_ROWS  = ROWS / 2;
    localparam int ROW_W      = PIX_W * BLK;
    localparam int PAIR_W     = 2 * ROW_W;
    localparam int ROW_SAD_W  = PIX_W + $clog2(BLK);
    localparam int SAD_W      = 16;
    localparam int MV_W       = 8;
    localparam int CNT_W      = 16;
    localparam int R_IDX_W    = $clog2(ROWS);
    localparam int H_IDX_W    = $clog2(HALF_ROWS);
    localparam int MAX_SAD    = ROWS * BLK * ((1 << PIX_W) - 1);

    typedef logic [PIX_W-1:0]     pix_t;
    typedef logic [ROW_W-1:0]     row_t;
    typedef logic [SAD_W-1:0]     sad_t;
    typedef logic [ROW_SAD_W-1:0] rsad_t;
    typedef logic [CNT_W-1:0]     cnt_t;

    typedef struct packed {
        logic [MV_W-1:0] x;
        logic [MV_W-1:0] y;
    } mv_t;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_SEARCH,
        ST_DRAIN
    } mode_e;

    // State of the odd-row (second-half) sequencer
    typedef struct packed {
        logic               act;
        logic [H_IDX_W-1:0] row;
        sad_t               acc;
        mv_t                mv;
        logic               last;
    } p2_state_t;

    function automatic pix_t abs_diff(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic sad_t widen(input rsad_t v);
        return sad_t'(v);
    endfunction
endpackage

// File: rtl/tps_row_sad.sv
module tps_row_sad import tps_pkg::*; #(
    parameter int NPIX  = BLK,
    parameter int SUM_W = PIX_W + $clog2(NPIX)
) (
    input  logic [PIX_W*NPIX-1:0] ref_row,
    input  logic [PIX_W*NPIX-1:0] cur_row_i,
    output logic [SUM_W-1:0]      row_sum
);
    pix_t diff [NPIX];

    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        assign diff[g] = abs_diff(ref_row[g*PIX_W +: PIX_W], cur_row_i[g*PIX_W +: PIX_W]);
    end

    always_comb begin
        row_sum = '0;
        for (int i = 0; i < NPIX; i++) begin
            row_sum = row_sum + SUM_W'(diff[i]);
        end
    end
endmodule

// File: rtl/tps_row_bank.sv
module tps_row_bank import tps_pkg::*; #(
    parameter int DEPTH = ROWS,
    parameter int N_RD  = 1,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [IDX_W-1:0]           wr_idx,
    input  row_t                       wr_row,
    input  logic [N_RD-1:0][IDX_W-1:0] rd_idx,
    output row_t [N_RD-1:0]            rd_row
);
    row_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_row;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd_row[p] = mem[rd_idx[p]];
    end
endmodule

// File: rtl/tps_best_track.sv
module tps_best_track import tps_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic p1_end,
    input  logic p1_last,
    input  sad_t partial,
    input  logic p2_fin,
    input  logic p2_last,
    input  mv_t  p2_mv,
    input  sad_t full,
    output logic pass,
    output logic search_end,
    output logic done,
    output sad_t best_sad,
    output mv_t  best_mv,
    output cnt_t skip_count
);
    sad_t min_q;
    mv_t  run_mv_q;
    logic eff_hit;
    sad_t eff_min;
    mv_t  eff_mv;

    // A full result finishing this cycle is forwarded to the even-row compare
    assign eff_hit    = p2_fin && (full < min_q);
    assign eff_min    = eff_hit ? full  : min_q;
    assign eff_mv     = eff_hit ? p2_mv : run_mv_q;
    assign pass       = partial < eff_min;
    assign search_end = (p2_fin && p2_last) || (p1_end && !pass && p1_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            min_q      <= '1;
            run_mv_q   <= '0;
            done       <= 1'b0;
            best_sad   <= '0;
            best_mv    <= '0;
            skip_count <= '0;
        end else begin
            done <= search_end;
            if (clear || search_end) begin
                min_q    <= '1;
                run_mv_q <= '0;
            end else if (eff_hit) begin
                min_q    <= full;
                run_mv_q <= p2_mv;
            end
            if (search_end) begin
                best_sad <= eff_min;
                best_mv  <= eff_mv;
            end
            if (clear) begin
                skip_count <= '0;
            end else if (p1_end && !pass) begin
                skip_count <= skip_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/two_phase_sad_engine.sv
module two_phase_sad_engine import tps_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              cur_valid,
    output logic              cur_ready,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic              cand_valid,
    output logic              cand_ready,
    input  logic [PAIR_W-1:0] cand_pair,
    input  logic [MV_W-1:0]   cand_mv_x,
    input  logic [MV_W-1:0]   cand_mv_y,
    input  logic              cand_last,
    output logic              done,
    output logic [MV_W-1:0]   best_mv_x,
    output logic [MV_W-1:0]   best_mv_y,
    output logic [SAD_W-1:0]  best_sad,
    output logic [CNT_W-1:0]  skip_count
);
    mode_e              mode_q;
    logic [R_IDX_W-1:0] cur_idx_q;
    logic [H_IDX_W-1:0] beat_q;
    sad_t               acc1_q;
    p2_state_t          p2_q;

    logic cur_fire, cand_fire, load_done, p1_end, p2_fin, pass, search_end;
    sad_t partial, full;
    rsad_t even_sad, odd_sad;
    mv_t   cand_mv, best_mv;

    logic [1:0][R_IDX_W-1:0] cur_rd_idx;
    row_t [1:0]              cur_rd_row;
    logic [0:0][H_IDX_W-1:0] odd_rd_idx;
    row_t [0:0]              odd_rd_row;

    assign cur_ready  = (mode_q == ST_LOAD);
    assign cand_ready = (mode_q == ST_SEARCH);
    assign cur_fire   = cur_valid && cur_ready;
    assign cand_fire  = cand_valid && cand_ready;
    assign load_done  = cur_fire && (cur_idx_q == R_IDX_W'(ROWS - 1));
    assign p1_end     = cand_fire && (beat_q == H_IDX_W'(HALF_ROWS - 1));
    assign p2_fin     = p2_q.act && (p2_q.row == H_IDX_W'(HALF_ROWS - 1));
    assign cand_mv    = '{x: cand_mv_x, y: cand_mv_y};

    assign cur_rd_idx[0] = {beat_q, 1'b0};
    assign cur_rd_idx[1] = {p2_q.row, 1'b1};
    assign odd_rd_idx[0] = p2_q.row;

    tps_row_bank #(.DEPTH(ROWS), .N_RD(2)) u_cur_bank (
        .clk    (clk),
        .we     (cur_fire),
        .wr_idx (cur_idx_q),
        .wr_row (cur_row),
        .rd_idx (cur_rd_idx),
        .rd_row (cur_rd_row)
    );

    // Odd rows of the candidate in flight, kept for the second half
    tps_row_bank #(.DEPTH(HALF_ROWS), .N_RD(1)) u_odd_bank (
        .clk    (clk),
        .we     (cand_fire),
        .wr_idx (beat_q),
        .wr_row (cand_pair[PAIR_W-1:ROW_W]),
        .rd_idx (odd_rd_idx),
        .rd_row (odd_rd_row)
    );

    tps_row_sad #(.NPIX(BLK)) u_even_sad (
        .ref_row   (cand_pair[ROW_W-1:0]),
        .cur_row_i (cur_rd_row[0]),
        .row_sum   (even_sad)
    );

    tps_row_sad #(.NPIX(BLK)) u_odd_sad (
        .ref_row   (odd_rd_row[0]),
        .cur_row_i (cur_rd_row[1]),
        .row_sum   (odd_sad)
    );

    assign partial = acc1_q + widen(even_sad);
    assign full    = p2_q.acc + widen(odd_sad);

    tps_best_track u_track (
        .clk        (clk),
        .rst        (rst),
        .clear      (load_done),
        .p1_end     (p1_end),
        .p1_last    (cand_last),
        .partial    (partial),
        .p2_fin     (p2_fin),
        .p2_last    (p2_q.last),
        .p2_mv      (p2_q.mv),
        .full       (full),
        .pass       (pass),
        .search_end (search_end),
        .done       (done),
        .best_sad   (best_sad),
        .best_mv    (best_mv),
        .skip_count (skip_count)
    );

    assign best_mv_x = best_mv.x;
    assign best_mv_y = best_mv.y;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= ST_LOAD;
            cur_idx_q <= '0;
            beat_q    <= '0;
            acc1_q    <= '0;
        end else begin
            if (cur_fire) begin
                cur_idx_q <= cur_idx_q + 1'b1;
            end
            if (cand_fire) begin
                beat_q <= beat_q + 1'b1;
                acc1_q <= p1_end ? '0 : partial;
            end
            unique case (mode_q)
                ST_LOAD:   if (load_done) mode_q <= ST_SEARCH;
                ST_SEARCH: if (p1_end && cand_last) mode_q <= search_end ? ST_LOAD : ST_DRAIN;
                ST_DRAIN:  if (search_end) mode_q <= ST_LOAD;
                default:   mode_q <= ST_LOAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p2_q <= '0;
        end else if (p1_end && pass) begin
            p2_q <= '{act: 1'b1, row: '0, acc: partial, mv: cand_mv, last: cand_last};
        end else if (p2_fin) begin
            p2_q.act <= 1'b0;
        end else if (p2_q.act) begin
            p2_q.row <= p2_q.row + 1'b1;
            p2_q.acc <= full;
        end
    end
endmodule

// File: rtl/tps_sva.sv
module tps_sva import tps_pkg::*; (
    input logic       clk,
    input logic       rst,
    input logic       cur_ready,
    input logic       cand_ready,
    input logic       done,
    input logic       p1_end,
    input logic       pass,
    input logic       p2_act,
    input logic       p2_fin,
    input logic       search_end,
    input sad_t       best_sad,
    input cnt_t       skip_count
);
    p_ready_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(cur_ready && cand_ready));

    p_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        (p1_end && pass && p2_act) |-> p2_fin);

    p_skip_step_r4: assert property (@(posedge clk) disable iff (rst)
        (p1_end && !pass) |=> (skip_count == CNT_W'($past(skip_count) + 1'b1)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_end_reload_r10: assert property (@(posedge clk) disable iff (rst)
        search_end |=> (cur_ready && done));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(best_sad) <= MAX_SAD));
endmodule

bind two_phase_sad_engine tps_sva i_sva (
    .clk        (clk),
    .rst        (rst),
    .cur_ready  (cur_ready),
    .cand_ready (cand_ready),
    .done       (done),
    .p1_end     (p1_end),
    .pass       (pass),
    .p2_act     (p2_q.act),
    .p2_fin     (p2_fin),
    .search_end (search_end),
    .best_sad   (best_sad),
    .skip_count (skip_count)
);

// File: tb/test_two_phase_sad_engine.sv
module test_two_phase_sad_engine;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cur_valid = 1'b0;
    logic         cur_ready;
    logic [127:0] cur_row = '0;
    logic         cand_valid = 1'b0;
    logic         cand_ready;
    logic [255:0] cand_pair = '0;
    logic [7:0]   cand_mv_x = '0;
    logic [7:0]   cand_mv_y = '0;
    logic         cand_last = 1'b0;
    logic         done;
    logic [7:0]   best_mv_x;
    logic [7:0]   best_mv_y;
    logic [15:0]  best_sad;
    logic [15:0]  skip_count;

    two_phase_sad_engine i_two_phase_sad_engine (.*);

    always #(CLK_P/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int edge_n = 0;
    int exp_done_edge = -1;
    bit finished = 0;
    int cur_px [16][16];
    int cpx [16][16];
    int m_min, m_skip, m_bx, m_by;

    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of the completion pulse and the results it presents
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_done;
            exp_done = (edge_n == exp_done_edge);
            check(done == exp_done, "R9", "done timing", int'(done), int'(exp_done));
            if (exp_done) begin
                check(int'(best_sad) == m_min, "R5/R6/R8", "best_sad", int'(best_sad), m_min);
                check(int'($signed(best_mv_x)) == m_bx, "R6", "best_mv_x", int'($signed(best_mv_x)), m_bx);
                check(int'($signed(best_mv_y)) == m_by, "R6", "best_mv_y", int'($signed(best_mv_y)), m_by);
                check(int'(skip_count) == m_skip, "R4", "skip_count", int'(skip_count), m_skip);
            end
        end
    end

    function automatic int clamp(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic load_cur(input bit zeros);
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                cur_px[r][c] = zeros ? 0 : 60 + ((r * 37 + c * 11) % 120);
                cur_row[c*8 +: 8] = 8'(cur_px[r][c]);
            end
            cur_valid = 1'b1;
            @(negedge clk);
        end
        cur_valid = 1'b0;
        // R2: loading finished, candidates now accepted
        check(cur_ready == 1'b0, "R2", "cur_ready after load", int'(cur_ready), 0);
        check(cand_ready == 1'b1, "R2", "cand_ready after load", int'(cand_ready), 1);
        m_min = 65535; m_skip = 0; m_bx = 0; m_by = 0;
    endtask

    task automatic send_cand(input int mvx, input int mvy, input int de, input int dodd,
                             input int seed, input bit last, input bit bubble);
        int even_s, odd_s, full_s;
        bit passed;
        even_s = 0; odd_s = 0; passed = 0;
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                int n;
                n = (seed == 0) ? 0 : ((r * 5 + c * 3 + seed) % 7) - 3;
                cpx[r][c] = clamp(cur_px[r][c] + ((r % 2 == 0) ? de : dodd) + n);
                if (r % 2 == 0) even_s += iabs(cpx[r][c] - cur_px[r][c]);
                else            odd_s  += iabs(cpx[r][c] - cur_px[r][c]);
            end
        end
        for (int k = 0; k < 8; k++) begin
            if (bubble && (k == 3 || k == 6)) begin
                cand_valid = 1'b0;
                @(negedge clk);
                @(negedge clk);
            end
            for (int c = 0; c < 16; c++) begin
                cand_pair[c*8 +: 8]       = 8'(cpx[2*k][c]);
                cand_pair[128 + c*8 +: 8] = 8'(cpx[2*k+1][c]);
            end
            cand_valid = 1'b1;
            cand_last  = (k == 7) && last;
            cand_mv_x  = (k == 7) ? 8'(mvx) : 8'hA5;
            cand_mv_y  = (k == 7) ? 8'(mvy) : 8'h5A;
            if (k == 7) begin
                // Sequential reference: compare even half with bound, then full
                if (even_s < m_min) begin
                    passed = 1;
                    full_s = even_s + odd_s;
                    if (full_s < m_min) begin
                        m_min = full_s; m_bx = mvx; m_by = mvy;
                    end
                end else begin
                    m_skip++;
                end
                if (last) exp_done_edge = edge_n + 1 + (passed ? 8 : 0);
            end
            @(negedge clk);
        end
        cand_valid = 1'b0;
        cand_last  = 1'b0;
        if (last) begin
            // R10: no beats accepted while draining
            check(cand_ready == 1'b0, "R10", "cand_ready after last beat", int'(cand_ready), 0);
        end
    endtask

    task automatic finish_search();
        while (edge_n <= exp_done_edge) @(negedge clk);
        check(cur_ready == 1'b1, "R10", "cur_ready after done", int'(cur_ready), 1);
        check(cand_ready == 1'b0, "R10", "cand_ready after done", int'(cand_ready), 0);
        check(int'(skip_count) == m_skip, "R9", "skip_count held", int'(skip_count), m_skip);
        check(int'(best_sad) == m_min, "R9", "best_sad held", int'(best_sad), m_min);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(cur_ready == 1'b1, "R1", "cur_ready", int'(cur_ready), 1);
        check(cand_ready == 1'b0, "R1", "cand_ready", int'(cand_ready), 0);
        check(done == 1'b0, "R1", "done", int'(done), 0);
        check(best_sad == 16'd0, "R1", "best_sad", int'(best_sad), 0);
        check(best_mv_x == 8'd0 && best_mv_y == 8'd0, "R1", "best_mv", int'(best_mv_x), 0);
        check(skip_count == 16'd0, "R1", "skip_count", int'(skip_count), 0);

        // Search 1 (R3, R4, R5, R6, R7): seed, drop, pass-but-lose, win, tie
        load_cur(1'b0);
        send_cand(0, 0, 5, 5, 0, 1'b0, 1'b0);
        send_cand(1, 0, 30, 30, 0, 1'b0, 1'b0);
        send_cand(-2, 3, 0, 40, 2, 1'b0, 1'b0);
        send_cand(4, -1, 1, 1, 0, 1'b0, 1'b0);
        send_cand(7, 7, 1, 1, 0, 1'b1, 1'b0);
        finish_search();

        // Search 2 (R11, R9): idle gaps, exact match, final candidate dropped
        load_cur(1'b0);
        send_cand(2, 2, -3, 2, 4, 1'b0, 1'b1);
        send_cand(3, -3, 0, 0, 0, 1'b0, 1'b1);
        send_cand(-5, -6, -20, 0, 0, 1'b1, 1'b1);
        finish_search();

        // Search 3 (R8, R7): largest possible SAD from a single candidate
        load_cur(1'b1);
        send_cand(-128, 127, 255, 255, 0, 1'b1, 1'b0);
        finish_search();
        check(int'(best_sad) == 65280, "R8", "max SAD", int'(best_sad), 65280);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", edge_n, exp_done_edge);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule